// File: doc/BRIEF.md
# Programmable Pulse-Width Modulator with Prescaler

This block produces a single pulse-width modulated output whose period, duty and timebase are set through a small bank of memory-mapped registers. A 12-bit prescaler divides a selected clock-enable stream. The divided ticks drive a period counter that restarts after the programmed period value plus two ticks. The output is high from the start of every period for as many ticks as the sample (duty) register holds, and low for the rest of the period.

Software writes the sample and period registers and then sets the enable bit in the control register. Sample and period values written while the generator runs are held back and take effect at the next period boundary, so a period in progress keeps its shape. The control register also chooses which of two clock-enable streams feeds the prescaler. It also holds three run-permission bits. These let the count continue or freeze while the chip reports doze, wait or debug mode. Writing zero to the control register stops the generator and forces the output low. The programmed values are kept.

Top module: `duty_pwm`

## Requirements
- R1: Registers are at byte offsets 0x00 (control), 0x0C (sample) and 0x10 (period). Read data appears on the cycle after the address is presented. Control keeps only bits 0, 4..17 and 22..24, so mask 0x01C3FFF1 applies. Sample and period keep their low 16 bits and read back zero-extended. Any other offset reads zero.
- R2: After reset every register reads zero and the output is low.
- R3: Once enabled, each period lasts the period value plus 2 counter ticks. The output is high for the first "sample" ticks of each period and low for the remaining ticks.
- R4: A sample value of 0 keeps the output low. A sample value equal to or larger than the period value plus 2 keeps the output high.
- R5: Control bits [15:4] hold the prescale value P. The counter advances once every P+1 selected source ticks.
- R6: Control bits [17:16] pick the tick source. Value 1 uses ref_tick_i and value 2 uses fast_tick_i. Values 0 and 3 select nothing, so the counter does not move.
- R7: Control bits 24, 23 and 22 are run permissions for doze_i, wait_i and debug_i respectively. While a permission bit is 0 and its mode input is 1, counting freezes. While the bit is 1, the mode input has no effect.
- R8: Sample and period values written during a period take effect at the next period boundary. The current period keeps its old high and low lengths.
- R9: Control bit 0 enables the generator. While it is 0, the output is low and the counter and prescaler are held at zero, and register contents are kept. Setting it again starts a fresh period from its beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 5 | Register byte offset |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Registered read data for the previous cycle's address |
| ref_tick_i | input | 1 | Normal peripheral clock enable (source 1) |
| fast_tick_i | input | 1 | High-frequency peripheral clock enable (source 2) |
| doze_i | input | 1 | Chip is in doze mode |
| wait_i | input | 1 | Chip is in wait mode |
| debug_i | input | 1 | Chip is halted for debug |
| pwm_o | output | 1 | Modulated output |

## Verification
The bench measures high and low run lengths in clock cycles. This catches an off-by-one in the period-plus-two rule or in the prescale divide, because either one shifts a run by a whole tick. A sample update written mid-period exposes a design that loads new values at once, since that would stretch or cut the running high phase. The duty extremes (zero, and equal to the period length) and period value 0 catch comparisons with the wrong bound. Freezing in doze, ignoring a mode input whose run bit is set, the invalid source codes, and a re-enable after a mid-period stop each show a design that counts through or resumes a stale count.

// File: rtl/duty_pwm_pkg.sv
package duty_pwm_pkg;

  localparam int DATA_W = 32;
  localparam int PRE_W  = 12;

  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_SAMPLE = 'h0C;
  localparam int OFS_PERIOD = 'h10;

  // bits of the control word that are stored
  localparam logic [DATA_W-1:0] CTRL_KEEP = 32'h01C3_FFF1;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_REF  = 2'd1,
    SRC_FAST = 2'd2,
    SRC_RSVD = 2'd3
  } tick_src_e;

  typedef struct packed {
    logic             doze_run;
    logic             wait_run;
    logic             dbg_run;
    tick_src_e        src;
    logic [PRE_W-1:0] presc;
    logic             en;
  } ctrl_t;

  function automatic ctrl_t decode_ctrl(input logic [DATA_W-1:0] w);
    ctrl_t c;
    c.en       = w[0];
    c.presc    = w[15:4];
    c.src      = tick_src_e'(w[17:16]);
    c.dbg_run  = w[22];
    c.wait_run = w[23];
    c.doze_run = w[24];
    return c;
  endfunction

endpackage

// File: rtl/duty_pwm_regs.sv
module duty_pwm_regs
  import duty_pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [CNT_W-1:0]  sample_o,
  output logic [CNT_W-1:0]  period_o
);

  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_SAMPLE = ADDR_W'(OFS_SAMPLE);
  localparam logic [ADDR_W-1:0] A_PERIOD = ADDR_W'(OFS_PERIOD);
  localparam int PAD_W = DATA_W - CNT_W;

  logic [DATA_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  sample_q;
  logic [CNT_W-1:0]  period_q;
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    case (addr_i)
      A_CTRL:   rd_next = ctrl_q;
      A_SAMPLE: rd_next = {{PAD_W{1'b0}}, sample_q};
      A_PERIOD: rd_next = {{PAD_W{1'b0}}, period_q};
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      sample_q <= '0;
      period_q <= '0;
      rdata_o  <= '0;
    end else begin
      rdata_o <= rd_next;
      if (we_i) begin
        case (addr_i)
          A_CTRL:   ctrl_q   <= wdata_i & CTRL_KEEP;
          A_SAMPLE: sample_q <= wdata_i[CNT_W-1:0];
          A_PERIOD: period_q <= wdata_i[CNT_W-1:0];
          default:  ;
        endcase
      end
    end
  end

  assign ctrl_o   = ctrl_q;
  assign sample_o = sample_q;
  assign period_o = period_q;

endmodule

// File: rtl/duty_pwm_tick.sv
module duty_pwm_tick
  import duty_pwm_pkg::*;
#(
  parameter int PW   = 12,
  parameter int LP_N = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  tick_src_e       src_i,
  input  logic [PW-1:0]   presc_i,
  input  logic            ref_tick_i,
  input  logic            fast_tick_i,
  input  logic [LP_N-1:0] lp_req_i,
  input  logic [LP_N-1:0] lp_run_i,
  output logic            frozen_o,
  output logic            adv_o,
  output logic            cnt_tick_o
);

  logic [LP_N-1:0] hold_vec;
  logic            src_tick;
  logic [PW-1:0]   div_q;

  for (genvar g = 0; g < LP_N; g++) begin : g_hold
    assign hold_vec[g] = lp_req_i[g] & ~lp_run_i[g];
  end

  always_comb begin
    case (src_i)
      SRC_REF:  src_tick = ref_tick_i;
      SRC_FAST: src_tick = fast_tick_i;
      default:  src_tick = 1'b0;
    endcase
  end

  assign frozen_o   = |hold_vec;
  assign adv_o      = en_i & src_tick & ~frozen_o;
  assign cnt_tick_o = adv_o & (div_q >= presc_i);

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i)  div_q <= '0;
    else if (cnt_tick_o)  div_q <= '0;
    else if (adv_o)       div_q <= div_q + 1'b1;
  end

endmodule

// File: rtl/duty_pwm_period.sv
module duty_pwm_period #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             cnt_tick_i,
  input  logic [CNT_W-1:0] sample_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W:0]   cnt_o,
  output logic [CNT_W-1:0] act_sample_o,
  output logic [CNT_W-1:0] act_period_o,
  output logic             wrap_o,
  output logic             pwm_o
);

  localparam int CW = CNT_W + 1;

  function automatic logic [CW-1:0] last_count(input logic [CNT_W-1:0] p);
    return {1'b0, p} + CW'(1);
  endfunction

  logic [CW-1:0]    cnt_q;
  logic [CNT_W-1:0] smp_q;
  logic [CNT_W-1:0] per_q;

  assign wrap_o = cnt_tick_i & (cnt_q >= last_count(per_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      smp_q <= '0;
      per_q <= '0;
    end else if (!en_i || wrap_o) begin
      cnt_q <= '0;
      smp_q <= sample_i;
      per_q <= period_i;
    end else if (cnt_tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign pwm_o        = en_i & (cnt_q < {1'b0, smp_q});
  assign cnt_o        = cnt_q;
  assign act_sample_o = smp_q;
  assign act_period_o = per_q;

endmodule

// File: rtl/duty_pwm.sv
module duty_pwm
  import duty_pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              ref_tick_i,
  input  logic              fast_tick_i,
  input  logic              doze_i,
  input  logic              wait_i,
  input  logic              debug_i,
  output logic              pwm_o
);

  localparam int LP_N = 3;

  logic [DATA_W-1:0] ctrl_word;
  logic [CNT_W-1:0]  sample_reg;
  logic [CNT_W-1:0]  period_reg;
  ctrl_t             ctl;
  logic              run_en;
  logic [LP_N-1:0]   lp_req;
  logic [LP_N-1:0]   lp_run;
  logic              frozen;
  logic              pre_adv;
  logic              cnt_tick;
  logic              wrap;
  logic [CNT_W:0]    cnt;
  logic [CNT_W-1:0]  act_sample;
  logic [CNT_W-1:0]  act_period;

  duty_pwm_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o), .ctrl_o(ctrl_word),
    .sample_o(sample_reg), .period_o(period_reg)
  );

  assign ctl    = decode_ctrl(ctrl_word);
  assign run_en = ctl.en;
  // index order follows the control bits 22, 23, 24
  assign lp_req = {doze_i, wait_i, debug_i};
  assign lp_run = {ctl.doze_run, ctl.wait_run, ctl.dbg_run};

  duty_pwm_tick #(.PW(PRE_W), .LP_N(LP_N)) u_tick (
    .clk(clk), .rst_n(rst_n), .en_i(run_en), .src_i(ctl.src),
    .presc_i(ctl.presc), .ref_tick_i(ref_tick_i), .fast_tick_i(fast_tick_i),
    .lp_req_i(lp_req), .lp_run_i(lp_run), .frozen_o(frozen),
    .adv_o(pre_adv), .cnt_tick_o(cnt_tick)
  );

  duty_pwm_period #(.CNT_W(CNT_W)) u_period (
    .clk(clk), .rst_n(rst_n), .en_i(run_en), .cnt_tick_i(cnt_tick),
    .sample_i(sample_reg), .period_i(period_reg), .cnt_o(cnt),
    .act_sample_o(act_sample), .act_period_o(act_period),
    .wrap_o(wrap), .pwm_o(pwm_o)
  );

endmodule

// File: rtl/duty_pwm_chk.sv
module duty_pwm_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [1:0]       src,
  input logic             frozen,
  input logic             adv,
  input logic             cnt_tick,
  input logic             wrap,
  input logic [CNT_W:0]   cnt,
  input logic [CNT_W-1:0] act_sample,
  input logic [CNT_W-1:0] act_period,
  input logic             pwm
);

  a_r9_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm);

  a_r9_off_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));

  a_r3_cnt_limit: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt <= ({1'b0, act_period} + (CNT_W+1)'(1))));

  a_r3_wrap_restart: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

  a_r6_no_source: assert property (@(posedge clk) disable iff (!rst_n)
    (src == 2'd0 || src == 2'd3) |-> !adv);

  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> !cnt_tick);

  a_r8_hold_values: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap) |=> ($stable(act_sample) && $stable(act_period)));

  a_r4_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (act_sample == '0) |-> !pwm);

endmodule

bind duty_pwm duty_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(run_en), .src(ctl.src), .frozen(frozen),
  .adv(pre_adv), .cnt_tick(cnt_tick), .wrap(wrap), .cnt(cnt),
  .act_sample(act_sample), .act_period(act_period), .pwm(pwm_o)
);

// File: tb/duty_pwm_tb_top.sv
module duty_pwm_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ref_tick = 1'b1;
  logic        fast_tick = 1'b1;
  logic        doze = 1'b0;
  logic        waitm = 1'b0;
  logic        dbg = 1'b0;
  logic        pwm;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    int    hi;
    int    lo;
    string req;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  duty_pwm dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ref_tick_i(ref_tick),
    .fast_tick_i(fast_tick), .doze_i(doze), .wait_i(waitm),
    .debug_i(dbg), .pwm_o(pwm)
  );

  task automatic check_eq(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd_check(string req, input logic [4:0] a, input logic [31:0] exp);
    @(posedge clk); #1;
    addr = a;
    @(posedge clk); #1;
    check_eq(req, rdata, exp);
  endtask

  // program while stopped, then enable with the given control word
  task automatic start(input logic [31:0] c, input int s, input int p);
    wr(5'h00, 32'h0);
    wr(5'h0C, s);
    wr(5'h10, p);
    wr(5'h00, c);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(posedge clk);
  endtask

  task automatic hold_check(string req, input logic lvl, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm !== lvl) bad++;
    end
    check_eq(req, bad, 0);
  endtask

  // monitor: measures one high run and the following low run per item
  typedef enum int {M_IDLE, M_HIGH, M_LOW} mst_e;
  mst_e mst = M_IDLE;
  logic prev_l = 1'b0;
  int   hcnt = 0;
  int   lcnt = 0;

  always @(negedge clk) begin
    case (mst)
      M_IDLE: if (!prev_l && pwm && exp_q.size() > 0) begin
        hcnt = 1; mst = M_HIGH;
      end
      M_HIGH: if (pwm) hcnt++;
              else begin lcnt = 1; mst = M_LOW; end
      M_LOW: if (!pwm) lcnt++;
             else begin
               check_eq({exp_q[0].req, " high"}, hcnt, exp_q[0].hi);
               check_eq({exp_q[0].req, " low"}, lcnt, exp_q[0].lo);
               void'(exp_q.pop_front());
               if (exp_q.size() > 0) begin hcnt = 1; mst = M_HIGH; end
               else mst = M_IDLE;
             end
      default: mst = M_IDLE;
    endcase
    prev_l = pwm;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_eq("R2 output in reset", pwm, 0);
    rst_n = 1'b1;
    rd_check("R2 ctrl after reset", 5'h00, 32'h0);
    rd_check("R2 sample after reset", 5'h0C, 32'h0);
    rd_check("R2 period after reset", 5'h10, 32'h0);
    check_eq("R2 output after reset", pwm, 0);

    // R1 register map and masking
    wr(5'h00, 32'hFFFF_FFFE);
    rd_check("R1 ctrl mask", 5'h00, 32'h01C3_FFF0);
    wr(5'h0C, 32'hABCD_1234);
    rd_check("R1 sample width", 5'h0C, 32'h0000_1234);
    wr(5'h10, 32'h5555_BEEF);
    rd_check("R1 period width", 5'h10, 32'h0000_BEEF);
    rd_check("R1 unmapped 0x04", 5'h04, 32'h0);
    rd_check("R1 unmapped 0x1C", 5'h1C, 32'h0);
    wr(5'h00, 32'h0);

    // R3 basic shapes, source 1, no prescale
    exp_q.push_back('{3, 7, "R3 s3p8"});
    exp_q.push_back('{3, 7, "R3 s3p8 second"});
    start(32'h0001_0001, 3, 8);
    drain();
    exp_q.push_back('{1, 1, "R3 period zero"});
    start(32'h0001_0001, 1, 0);
    drain();

    // R4 duty extremes
    start(32'h0001_0001, 0, 5);
    hold_check("R4 sample zero low", 1'b0, 40);
    start(32'h0001_0001, 10, 8);
    hold_check("R4 sample equals length high", 1'b1, 40);

    // R5 prescale by 3
    exp_q.push_back('{6, 9, "R5 div3"});
    exp_q.push_back('{6, 9, "R5 div3 second"});
    start(32'h0001_0021, 2, 3);
    drain();

    // R6 source select
    ref_tick = 1'b0;
    exp_q.push_back('{3, 3, "R6 fast source"});
    start(32'h0002_0001, 3, 4);
    drain();
    ref_tick = 1'b1; fast_tick = 1'b0;
    exp_q.push_back('{3, 3, "R6 ref source"});
    start(32'h0001_0001, 3, 4);
    drain();
    fast_tick = 1'b1;
    start(32'h0000_0001, 2, 4);
    hold_check("R6 source 0 stalls", 1'b1, 40);
    start(32'h0003_0001, 2, 4);
    hold_check("R6 source 3 stalls", 1'b1, 40);

    // R7 low-power freeze and run permission
    exp_q.push_back('{7, 4, "R7 doze freeze"});
    start(32'h0001_0001, 4, 6);
    @(posedge clk); #1; doze = 1'b1;
    repeat (3) @(posedge clk);
    #1; doze = 1'b0;
    drain();
    doze = 1'b1;
    exp_q.push_back('{4, 4, "R7 doze permitted"});
    start(32'h0101_0001, 4, 6);
    drain();
    doze = 1'b0;
    dbg = 1'b1;
    start(32'h0001_0001, 2, 6);
    hold_check("R7 debug freeze", 1'b1, 30);
    dbg = 1'b0;
    waitm = 1'b1;
    exp_q.push_back('{2, 6, "R7 wait permitted"});
    start(32'h0081_0001, 2, 6);
    drain();
    waitm = 1'b0;

    // R8 update at boundary
    exp_q.push_back('{3, 7, "R8 old values kept"});
    exp_q.push_back('{5, 3, "R8 new values used"});
    start(32'h0001_0001, 3, 8);
    wr(5'h0C, 5);
    wr(5'h10, 6);
    drain();

    // R9 stop mid-period, keep registers, restart fresh
    start(32'h0001_0001, 3, 8);
    repeat (5) @(posedge clk);
    wr(5'h00, 32'h0);
    @(negedge clk);
    check_eq("R9 output low when stopped", pwm, 0);
    hold_check("R9 stays low", 1'b0, 10);
    rd_check("R9 sample kept", 5'h0C, 32'd3);
    rd_check("R9 period kept", 5'h10, 32'd8);
    exp_q.push_back('{3, 7, "R9 restart from start"});
    wr(5'h00, 32'h0001_0001);
    drain();
    wr(5'h00, 32'h0);

    repeat (5) @(posedge clk);
    summary();
  end

endmodule